// File: doc/BRIEF.md
# DRAM Write-Drain Mode Arbiter

This block decides whether a DRAM controller's shared data bus serves reads or drains buffered writes. It also decides when the next command may start. It watches write-queue and read-queue occupancy.

Drain mode begins when the write queue climbs to a high watermark and stops reads. Drain mode ends when the write queue falls to a low watermark while reads are waiting, or when it empties. Each write is issued one at a time, at its own timing-constrained start, and the mode is re-decided after every write.

The block keeps its own record of the time until which the data bus is reserved. Each return to reads adds a write-to-read turnaround to that time. From the bus reservation and the precharge, activate and column latencies, it derives the earliest cycle at which a further command may start. It tracks one scheduled read start and only ever moves that start earlier.

Top module: `drain_arbiter`

## Requirements
- R1: With the default parameters (depth 16, high percentage 75, low percentage 25), the high mark is 12 entries and the low mark is 4 entries. Each mark is depth times percentage divided by 100, rounded down.
- R2: In read mode, `write_mode` and `stop_reads` go to 1 one cycle after the cycle in which `wq_count` is at least the high mark. They never go to 1 while `wq_count` is 0 or below the high mark.
- R3: In write mode, `write_en` is 1 exactly when the cycle counter has reached the write start time. That start time is recorded as `next_time` on entry to write mode and again on every write that keeps write mode.
- R4: A `wr_done` pulse in write mode counts as one issued write, and the occupancy after it is `wq_count - 1`. Read mode resumes on the next edge if that occupancy is 0, or if it is at most the low mark with `rq_count` non-zero. Otherwise write mode continues.
- R5: On the return to read mode, `bus_busy_until` becomes its previous value plus `t_wtr`, `stop_reads` clears and `drain_count` resets to 0.
- R6: Let L = `t_rp + t_rcd + t_cl`. If `bus_busy_until` > L, then `next_time` = max(`bus_busy_until` - L, current cycle). Otherwise `next_time` equals the current cycle, which counts edges since reset starting from 0.
- R7: `drain_count` increments on every write that keeps write mode. `hi_reached` is 1 while `drain_count` is at least the high mark, and this does not by itself end write mode.
- R8: On the return to read mode, a read is scheduled at the updated `bus_busy_until` only if `read_sched` is 0. An existing schedule keeps its time.
- R9: While a read is scheduled and `rd_take` is 0, `read_at` moves down to `next_time` whenever `next_time` is smaller, and it never moves later. `rd_take` clears `read_sched`.
- R10: A synchronous active-high reset gives read mode, `stop_reads` 0, `drain_count` 0, `bus_busy_until` 0, no read scheduled, and cycle counter 0.
- R11: A `bus_upd` pulse loads `bus_upd_time` into `bus_busy_until` on the next edge. If a return to reads happens on the same edge, `t_wtr` is added to the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| wq_count | input | QW | write-queue occupancy, including a write issued this cycle |
| rq_count | input | RQW | read-queue occupancy |
| wr_done | input | 1 | one write issued this cycle |
| bus_upd | input | 1 | load a new bus reservation |
| bus_upd_time | input | TW | new bus-busy-until value |
| rd_take | input | 1 | the scheduled read has been taken |
| t_wtr | input | PW | write-to-read turnaround |
| t_rp | input | PW | precharge latency |
| t_rcd | input | PW | activate-to-column latency |
| t_cl | input | PW | column latency |
| write_mode | output | 1 | 1 while draining writes |
| stop_reads | output | 1 | reads held off |
| write_en | output | 1 | a write may start now |
| next_time | output | TW | earliest next-command cycle |
| bus_busy_until | output | TW | bus reserved until this cycle |
| drain_count | output | TW | writes issued in the current drain |
| hi_reached | output | 1 | drain count at or above the high mark |
| read_sched | output | 1 | a read start is scheduled |
| read_at | output | TW | scheduled read start cycle |

## Verification
Occupancies of 11 and 0 against one of 12 separate the high-mark rounding from an off-by-one, and the empty-queue guard from the threshold compare. A drain that pulls occupancy down to the low mark with reads waiting is set against one with an empty read queue, which must keep draining at the same mark and leave only when the queue empties. Bus reservations far above and at the summed latency exercise both branches of the next-command formula. A later larger reservation shows that a scheduled read is never pushed back.

// File: rtl/drain_arbiter.sv
module drain_arbiter #(
  parameter int DEPTH  = 16,
  parameter int HI_PCT = 75,
  parameter int LO_PCT = 25,
  parameter int TW     = 16,
  parameter int PW     = 8,
  parameter int RQW    = 5,
  localparam int QW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [QW-1:0] wq_count,
  input  logic [RQW-1:0] rq_count,
  input  logic          wr_done,
  input  logic          bus_upd,
  input  logic [TW-1:0] bus_upd_time,
  input  logic          rd_take,
  input  logic [PW-1:0] t_wtr,
  input  logic [PW-1:0] t_rp,
  input  logic [PW-1:0] t_rcd,
  input  logic [PW-1:0] t_cl,
  output logic          write_mode,
  output logic          stop_reads,
  output logic          write_en,
  output logic [TW-1:0] next_time,
  output logic [TW-1:0] bus_busy_until,
  output logic [TW-1:0] drain_count,
  output logic          hi_reached,
  output logic          read_sched,
  output logic [TW-1:0] read_at
);
  localparam int HI = DEPTH * HI_PCT / 100;
  localparam int LO = DEPTH * LO_PCT / 100;

  logic [TW-1:0] now, wr_at, lat, gap, bbu_base;
  logic [QW-1:0] post;
  logic enter, back;

  assign lat      = TW'(t_rp) + TW'(t_rcd) + TW'(t_cl);
  assign gap      = bus_busy_until - lat;
  assign next_time = (bus_busy_until > lat && gap > now) ? gap : now;
  assign post     = (wq_count == '0) ? '0 : wq_count - 1'b1;
  assign enter    = !write_mode && wq_count != '0 && wq_count >= QW'(HI);
  assign back     = write_mode && wr_done &&
                    (post == '0 || (post <= QW'(LO) && rq_count != '0));
  assign bbu_base = bus_upd ? bus_upd_time : bus_busy_until;
  assign write_en = write_mode && now >= wr_at;
  assign hi_reached = drain_count >= TW'(HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      now <= '0;
      wr_at <= '0;
      write_mode <= 1'b0;
      stop_reads <= 1'b0;
      drain_count <= '0;
      bus_busy_until <= '0;
      read_sched <= 1'b0;
      read_at <= '0;
    end else begin
      now <= now + 1'b1;
      bus_busy_until <= back ? bbu_base + TW'(t_wtr) : bbu_base;
      if (enter) begin
        write_mode <= 1'b1;
        stop_reads <= 1'b1;
        wr_at <= next_time;
      end else if (back) begin
        write_mode <= 1'b0;
        stop_reads <= 1'b0;
        drain_count <= '0;
      end else if (write_mode && wr_done) begin
        drain_count <= drain_count + 1'b1;
        wr_at <= next_time;
      end
      if (rd_take) begin
        read_sched <= 1'b0;
      end else if (back && !read_sched) begin
        read_sched <= 1'b1;
        read_at <= bbu_base + TW'(t_wtr);
      end else if (read_sched && next_time < read_at) begin
        read_at <= next_time;
      end
    end
  end

  assert_enter_R2: assert property (@(posedge clk) disable iff (rst)
    enter |=> write_mode && stop_reads);
  assert_no_empty_drain_R2: assert property (@(posedge clk) disable iff (rst)
    (!write_mode && wq_count == '0) |=> !write_mode);
  assert_turnaround_R5: assert property (@(posedge clk) disable iff (rst)
    (back && !bus_upd) |=> bus_busy_until == $past(bus_busy_until) + TW'($past(t_wtr))
      && !stop_reads && drain_count == '0);
  assert_next_floor_R6: assert property (@(posedge clk) disable iff (rst)
    next_time >= now);
  assert_never_later_R9: assert property (@(posedge clk) disable iff (rst)
    (read_sched && !rd_take) |=> read_sched && read_at <= $past(read_at));
  assert_hi_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    (write_mode && wr_done && !back) |=> write_mode);
endmodule

// File: tb/test_drain_arbiter.sv
module test_drain_arbiter;
  localparam int PERIOD = 10;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] wq_count = '0;
  logic [4:0] rq_count = '0;
  logic wr_done = 1'b0, bus_upd = 1'b0, rd_take = 1'b0;
  logic [TW-1:0] bus_upd_time = '0;
  logic [7:0] t_wtr = 8'd5, t_rp = 8'd3, t_rcd = 8'd3, t_cl = 8'd4;
  logic write_mode, stop_reads, write_en, hi_reached, read_sched;
  logic [TW-1:0] next_time, bus_busy_until, drain_count, read_at;

  int checks = 0, fails = 0, cyc = 0;

  drain_arbiter i_drain_arbiter (
    .clk, .rst, .wq_count, .rq_count, .wr_done, .bus_upd, .bus_upd_time,
    .rd_take, .t_wtr, .t_rp, .t_rcd, .t_cl, .write_mode, .stop_reads,
    .write_en, .next_time, .bus_busy_until, .drain_count, .hi_reached,
    .read_sched, .read_at);

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic write_pulse(int occ);
    wq_count = 5'(occ);
    wr_done = 1'b1;
    tick();
    wr_done = 1'b0;
  endtask

  task automatic load_bus(int t);
    bus_upd = 1'b1;
    bus_upd_time = TW'(t);
    tick();
    bus_upd = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 mode", write_mode, 0);
    check("R10 stop", stop_reads, 0);
    check("R10 count", drain_count, 0);
    check("R10 bbu", bus_busy_until, 0);
    check("R10 sched", read_sched, 0);
    check("R6 next at cycle", next_time, cyc);
  endtask

  task automatic t_below_high();
    wq_count = 5'd11; tick(); tick();
    check("R1 below high mark", write_mode, 0);
    wq_count = 5'd0; tick();
    check("R2 empty queue", stop_reads, 0);
  endtask

  task automatic t_drain_with_reads();
    rq_count = 5'd2;
    load_bus(1000);
    check("R11 bbu load", bus_busy_until, 1000);
    check("R6 next from bbu", next_time, 990);
    wq_count = 5'd12; tick();
    check("R2 mode", write_mode, 1);
    check("R2 stop", stop_reads, 1);
    check("R3 not yet", write_en, 0);
    for (int k = 12; k >= 6; k--) write_pulse(k);
    check("R4 above low", write_mode, 1);
    check("R7 count", drain_count, 7);
    write_pulse(5);
    wq_count = 5'd0;
    check("R4 at low with reads", write_mode, 0);
    check("R5 stop", stop_reads, 0);
    check("R5 count", drain_count, 0);
    check("R5 bbu", bus_busy_until, 1005);
    check("R8 sched", read_sched, 1);
    check("R8 time", read_at, 1005);
    tick();
    check("R9 pull", read_at, 995);
  endtask

  task automatic t_hi_mark();
    rq_count = 5'd0;
    wq_count = 5'd14; tick();
    check("R2 mode again", write_mode, 1);
    for (int k = 0; k < 11; k++) write_pulse(14);
    check("R7 below mark", hi_reached, 0);
    write_pulse(14);
    check("R7 count", drain_count, 12);
    check("R7 mark seen", hi_reached, 1);
    check("R7 still draining", write_mode, 1);
    write_pulse(5);
    check("R4 low, no reads", write_mode, 1);
    write_pulse(1);
    wq_count = 5'd0;
    check("R4 empty", write_mode, 0);
    check("R5 bbu", bus_busy_until, 1010);
    check("R8 kept", read_at, 995);
  endtask

  task automatic t_pull();
    load_bus(500); tick();
    check("R9 earlier", read_at, 490);
    load_bus(2000); tick();
    check("R6 next", next_time, 1990);
    check("R9 not later", read_at, 490);
    rd_take = 1'b1; tick(); rd_take = 1'b0;
    check("R9 taken", read_sched, 0);
  endtask

  task automatic t_small_bus();
    load_bus(10);
    check("R6 at latency", next_time, cyc);
    wq_count = 5'd12; tick();
    check("R3 start", write_en, 1);
    write_pulse(1);
    wq_count = 5'd0;
    check("R5 bbu", bus_busy_until, 15);
    check("R8 new sched", read_sched, 1);
    check("R8 new time", read_at, 15);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_below_high();
    t_drain_with_reads();
    t_hi_mark();
    t_pull();
    t_small_bus();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 5000);
    checks++; fails++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule